// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Unit

This block is the host-facing control core of a network adapter. The host reaches it through one 16-bit command word, which holds a 5-bit opcode and an 11-bit argument. A single write can select a register window, enable, disable or reset the receive or transmit side, load an interrupt mask or a receive filter, raise a software interrupt, acknowledge chosen events, or start a global reset.

The block keeps a 16-bit status word. That word reports the selected window, a busy flag that stays high while a global reset completes, and a set of latched event bits fed by one-cycle pulses from the datapath. One interrupt output is raised while any latched event that the mask lets through is present. The block drives enable levels and one-cycle reset strobes towards the receive and transmit datapaths, together with the receive filter selection.

Top module: `ctl_cmd_status`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` is high. Its opcode is `cmd_word[15:11]` and its argument is `cmd_word[10:0]`. An opcode outside the set 0, 1, 3, 4, 5, 9, 10, 11, 12, 13, 14, 16 changes no output and no state.
- R2: Opcode 1 loads argument bits 2..0 into the window number. The window number appears on `status_word[15:13]` from the next cycle. Argument bits 10..3 have no effect.
- R3: Opcode 4 sets `rx_en` and opcode 3 clears it. Opcode 5 pulses `rx_rst` high for exactly one cycle and clears `rx_en`. After reset, `rx_en` is 0 until an opcode 4 arrives.
- R4: Opcode 9 sets `tx_en` and opcode 10 clears it. Opcode 11 pulses `tx_rst` high for exactly one cycle and clears `tx_en`.
- R5: A high bit of `evt_in` at positions 1, 2, 3, 4, 5 or 7 sets the matching latched bit of `status_word` in the next cycle, whatever the mask holds. `evt_in` bits 0 and 6 have no effect. When a set and an acknowledge hit the same bit in the same cycle, the set wins.
- R6: Opcode 12 sets status bit 6 (interrupt requested) in the next cycle.
- R7: Opcode 13 clears each latched status bit 1..7 whose argument bit is 1. All other latched bits keep their values.
- R8: Opcode 14 loads argument bits 7..1 as the interrupt mask. `status_word[0]` and `irq` are both equal to the OR of (latched bits 7..1 AND mask). They follow the stored state with no extra delay.
- R9: Opcode 16 loads argument bits 3..0 onto `rx_filter`. The bit meanings are: bit 0 individual, bit 1 multicast, bit 2 broadcast, bit 3 promiscuous.
- R10: Opcode 0 (global reset) sets `status_word[12]` for exactly RST_CYCLES cycles, starting in the next cycle. It clears the window, the mask, the filter, all latched events, `rx_en` and `tx_en`. Commands and events that arrive while `status_word[12]` is high are ignored.
- R11: After `rst_n` is deasserted, `status_word` is 0. `irq`, `rx_en`, `tx_en`, `rx_rst` and `tx_rst` are 0, and `rx_filter` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word is valid this cycle |
| cmd_word | input | 16 | Opcode [15:11], argument [10:0] |
| evt_in | input | 8 | One-cycle event pulses from the datapath, in status bit positions |
| status_word | output | 16 | Window [15:13], busy [12], zero [11:8], latched events [7:1], interrupt latch [0] |
| irq | output | 1 | Interrupt request |
| rx_en | output | 1 | Receive enable level |
| tx_en | output | 1 | Transmit enable level |
| rx_rst | output | 1 | One-cycle receive reset strobe |
| tx_rst | output | 1 | One-cycle transmit reset strobe |
| rx_filter | output | 4 | Receive filter selection |

## Verification
The hardest case to reach is a command or event that arrives in the same cycle as another effect on the same state. Examples are an acknowledge that meets a new event pulse on the same bit, and commands or pulses that land during the global-reset busy window, including its last busy cycle. Directed sequences place an event pulse and an acknowledge on one edge. They also keep issuing window-select commands and event pulses on every cycle of a global reset, and then confirm that nothing took effect. A randomized phase then mixes all opcodes, occasional global resets and random event bytes against a behavioural model on every cycle.

// File: rtl/ctl_cmd_pkg.sv
package ctl_cmd_pkg;

  localparam int CMD_W = 16;
  localparam int OP_W  = 5;
  localparam int ARG_W = CMD_W - OP_W;
  localparam int WIN_W = 3;
  localparam int FLT_W = 4;

  // event positions 7..1 that the datapath may set (bit 6 is internal)
  localparam logic [7:1] EXT_EVT_MASK = 7'b1011111;

  typedef enum logic [OP_W-1:0] {
    OP_GRESET = 5'd0,
    OP_WINSEL = 5'd1,
    OP_RXDIS  = 5'd3,
    OP_RXEN   = 5'd4,
    OP_RXRST  = 5'd5,
    OP_TXEN   = 5'd9,
    OP_TXDIS  = 5'd10,
    OP_TXRST  = 5'd11,
    OP_REQIRQ = 5'd12,
    OP_ACK    = 5'd13,
    OP_MASK   = 5'd14,
    OP_FILT   = 5'd16
  } op_e;

  typedef struct packed {
    logic greset;
    logic winsel;
    logic rx_dis;
    logic rx_en;
    logic rx_rst;
    logic tx_en;
    logic tx_dis;
    logic tx_rst;
    logic req_irq;
    logic ack;
    logic set_mask;
    logic set_filt;
  } act_t;

  function automatic logic [OP_W-1:0] cmd_op(input logic [CMD_W-1:0] w);
    return w[CMD_W-1:ARG_W];
  endfunction

  function automatic logic [ARG_W-1:0] cmd_arg(input logic [CMD_W-1:0] w);
    return w[ARG_W-1:0];
  endfunction

  // set has priority over clear
  function automatic logic [7:1] evt_next(input logic [7:1] cur,
                                           input logic [7:1] clr,
                                           input logic [7:1] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_of(input logic [7:1] ev, input logic [7:1] msk);
    return |(ev & msk);
  endfunction

endpackage

// File: rtl/ctl_cmd_decode.sv
module ctl_cmd_decode
  import ctl_cmd_pkg::*;
(
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             busy,
  output act_t             act,
  output logic [ARG_W-1:0] arg
);

  logic            take;
  logic [OP_W-1:0] op;

  assign take = cmd_valid && !busy;
  assign op   = cmd_op(cmd_word);
  assign arg  = cmd_arg(cmd_word);

  always_comb begin
    act = '0;
    if (take) begin
      case (op)
        OP_GRESET: act.greset   = 1'b1;
        OP_WINSEL: act.winsel   = 1'b1;
        OP_RXDIS:  act.rx_dis   = 1'b1;
        OP_RXEN:   act.rx_en    = 1'b1;
        OP_RXRST:  act.rx_rst   = 1'b1;
        OP_TXEN:   act.tx_en    = 1'b1;
        OP_TXDIS:  act.tx_dis   = 1'b1;
        OP_TXRST:  act.tx_rst   = 1'b1;
        OP_REQIRQ: act.req_irq  = 1'b1;
        OP_ACK:    act.ack      = 1'b1;
        OP_MASK:   act.set_mask = 1'b1;
        OP_FILT:   act.set_filt = 1'b1;
        default:   act          = '0;
      endcase
    end
  end

endmodule

// File: rtl/ctl_reset_timer.sv
module ctl_reset_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // checker: length of each busy run
  int run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  a_r10_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  a_r10_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == CYCLES));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: rtl/ctl_evt_latch.sv
module ctl_evt_latch
  import ctl_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_all,
  input  logic [7:1] set,
  input  logic       ack_en,
  input  logic [7:1] ack_mask,
  input  logic       mask_load,
  input  logic [7:1] mask_val,
  output logic [7:1] ev,
  output logic       irq_o
);

  logic [7:1] msk;
  logic [7:1] clr_eff;

  assign clr_eff = ack_en ? ack_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ev <= '0;
    else if (clr_all) ev <= '0;
    else              ev <= evt_next(ev, clr_eff, set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         msk <= '0;
    else if (clr_all)   msk <= '0;
    else if (mask_load) msk <= mask_val;
  end

  assign irq_o = irq_of(ev, msk);

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !clr_all) |=> ((ev & $past(ack_mask & ~set)) == 7'd0));

  a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set) && !clr_all) |=> ((ev & $past(set)) == $past(set)));

  a_r8_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(ack_en || clr_all || mask_load));

endmodule

// File: rtl/ctl_dir_ctrl.sv
module ctl_dir_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en_cmd,
  input  logic dis_cmd,
  input  logic rst_cmd,
  output logic en_o,
  output logic rst_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          en_o <= 1'b0;
    else if (clr || rst_cmd || dis_cmd)  en_o <= 1'b0;
    else if (en_cmd)                     en_o <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_o <= 1'b0;
    else        rst_o <= rst_cmd;
  end

  // R3 (receive) and R4 (transmit): a reset strobe leaves the side disabled
  a_r3_rst_disables: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |-> !en_o);

  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_o && !$past(rst_cmd)) |-> 1'b0);

endmodule

// File: rtl/ctl_cmd_status.sv
module ctl_cmd_status
  import ctl_cmd_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic [7:0]       evt_in,
  output logic [CMD_W-1:0] status_word,
  output logic             irq,
  output logic             rx_en,
  output logic             tx_en,
  output logic             rx_rst,
  output logic             tx_rst,
  output logic [FLT_W-1:0] rx_filter
);

  localparam int NDIR = 2;

  act_t             act;
  logic [ARG_W-1:0] arg;
  logic             busy;
  logic [7:1]       evt_set;
  logic [7:1]       ev;
  logic             irq_lat;
  logic [WIN_W-1:0] win_q;
  logic [FLT_W-1:0] filt_q;

  logic unused_bits;
  assign unused_bits = ^{arg[ARG_W-1:8], evt_in[0]};

  ctl_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .busy      (busy),
    .act       (act),
    .arg       (arg)
  );

  ctl_reset_timer #(.CYCLES(RST_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (act.greset),
    .busy  (busy)
  );

  assign evt_set = busy ? 7'd0
                 : ((evt_in[7:1] & EXT_EVT_MASK) | {1'b0, act.req_irq, 5'd0});

  ctl_evt_latch u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (act.greset),
    .set       (evt_set),
    .ack_en    (act.ack),
    .ack_mask  (arg[7:1]),
    .mask_load (act.set_mask),
    .mask_val  (arg[7:1]),
    .ev        (ev),
    .irq_o     (irq_lat)
  );

  // receive side at index 0, transmit side at index 1
  logic [NDIR-1:0] d_en, d_dis, d_rst, d_en_o, d_rst_o;
  assign d_en  = {act.tx_en,  act.rx_en};
  assign d_dis = {act.tx_dis, act.rx_dis};
  assign d_rst = {act.tx_rst, act.rx_rst};

  for (genvar gi = 0; gi < NDIR; gi++) begin : g_dir
    ctl_dir_ctrl u_dir (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (act.greset),
      .en_cmd  (d_en[gi]),
      .dis_cmd (d_dis[gi]),
      .rst_cmd (d_rst[gi]),
      .en_o    (d_en_o[gi]),
      .rst_o   (d_rst_o[gi])
    );
  end

  assign rx_en  = d_en_o[0];
  assign tx_en  = d_en_o[1];
  assign rx_rst = d_rst_o[0];
  assign tx_rst = d_rst_o[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          win_q <= '0;
    else if (act.greset) win_q <= '0;
    else if (act.winsel) win_q <= arg[WIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            filt_q <= '0;
    else if (act.greset)   filt_q <= '0;
    else if (act.set_filt) filt_q <= arg[FLT_W-1:0];
  end

  assign status_word = {win_q, busy, 4'b0000, ev, irq_lat};
  assign irq         = irq_lat;
  assign rx_filter   = filt_q;

  a_r10_greset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    act.greset |=> (status_word[15:13] == 3'd0 && rx_filter == 4'd0
                    && status_word[7:0] == 8'd0 && !rx_en && !tx_en));

  a_r6_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    act.req_irq |=> status_word[6]);

  a_r2_win_follows: assert property (@(posedge clk) disable iff (!rst_n)
    act.winsel |=> (status_word[15:13] == $past(arg[2:0])));

  a_r9_filt_follows: assert property (@(posedge clk) disable iff (!rst_n)
    act.set_filt |=> (rx_filter == $past(arg[3:0])));

endmodule

// File: tb/ctl_cmd_status_bench.sv
module ctl_cmd_status_bench;

  localparam int RST_N_CYC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = 16'd0;
  logic [7:0]  evt_in = 8'd0;
  logic [15:0] status_word;
  logic        irq, rx_en, tx_en, rx_rst, tx_rst;
  logic [3:0]  rx_filter;

  always #4 clk = ~clk;  // 125 MHz

  ctl_cmd_status #(.RST_CYCLES(RST_N_CYC)) u_ctl_cmd_status (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .evt_in(evt_in), .status_word(status_word), .irq(irq), .rx_en(rx_en),
    .tx_en(tx_en), .rx_rst(rx_rst), .tx_rst(tx_rst), .rx_filter(rx_filter)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string phase = "R11";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0] m_win;
  logic [7:0] m_mask, m_ev;
  logic [3:0] m_filt;
  logic       m_rxen, m_txen, m_rxr, m_txr;
  int         m_busy;

  initial begin
    m_win = 0; m_mask = 0; m_ev = 0; m_filt = 0;
    m_rxen = 0; m_txen = 0; m_rxr = 0; m_txr = 0; m_busy = 0;
  end

  always @(posedge clk or negedge rst_n) begin
    logic [4:0] op;
    logic [10:0] a;
    logic [7:0] setv, clrv;
    bit gr;
    if (!rst_n) begin
      m_win = 0; m_mask = 0; m_ev = 0; m_filt = 0;
      m_rxen = 0; m_txen = 0; m_rxr = 0; m_txr = 0; m_busy = 0;
    end else begin
      m_rxr = 0; m_txr = 0;
      if (m_busy > 0) begin
        m_busy = m_busy - 1;
      end else begin
        op = cmd_word[15:11];
        a = cmd_word[10:0];
        setv = evt_in & 8'hBE;
        clrv = 8'h00;
        gr = 0;
        if (cmd_valid) begin
          case (op)
            5'd0:  gr = 1;
            5'd1:  m_win = a[2:0];
            5'd3:  m_rxen = 0;
            5'd4:  m_rxen = 1;
            5'd5:  begin m_rxr = 1; m_rxen = 0; end
            5'd9:  m_txen = 1;
            5'd10: m_txen = 0;
            5'd11: begin m_txr = 1; m_txen = 0; end
            5'd12: setv = setv | 8'h40;
            5'd13: clrv = a[7:0];
            5'd14: m_mask = a[7:0] & 8'hFE;
            5'd16: m_filt = a[3:0];
            default: ;
          endcase
        end
        if (gr) begin
          m_win = 0; m_mask = 0; m_ev = 0; m_filt = 0;
          m_rxen = 0; m_txen = 0; m_busy = RST_N_CYC;
        end else begin
          m_ev = ((m_ev & ~clrv) | setv) & 8'hFE;
        end
      end
    end
  end

  function automatic logic [15:0] exp_status();
    logic lat;
    lat = |(m_ev & m_mask);
    return {m_win, (m_busy != 0), 4'b0000, m_ev[7:1], lat};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({phase, " status"}, {16'd0, status_word}, {16'd0, exp_status()});
      chk({phase, " irq"}, {31'd0, irq}, {31'd0, |(m_ev & m_mask)});
      chk({phase, " en/rst"}, {28'd0, rx_en, tx_en, rx_rst, tx_rst},
          {28'd0, m_rxen, m_txen, m_rxr, m_txr});
      chk({phase, " filter"}, {28'd0, rx_filter}, {28'd0, m_filt});
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input logic v, input logic [4:0] op, input logic [10:0] a,
                      input logic [7:0] e);
    cmd_valid = v;
    cmd_word = {op, a};
    evt_in = e;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word = 16'd0;
    evt_in = 8'd0;
  endtask

  task automatic idle();
    step(1'b0, 5'd0, 11'd0, 8'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R11";
    chk("R11 status after reset", {16'd0, status_word}, 32'd0);
    chk("R11 outputs after reset", {26'd0, irq, rx_en, tx_en, rx_rst, tx_rst, 1'b0},
        32'd0);
    chk("R11 filter after reset", {28'd0, rx_filter}, 32'd0);

    phase = "R2";
    step(1'b1, 5'd1, 11'h7FD, 8'd0);
    chk("R2 window select", {29'd0, status_word[15:13]}, 32'd5);

    phase = "R1";
    step(1'b1, 5'd31, 11'h7FF, 8'd0);
    step(1'b1, 5'd2, 11'h7FF, 8'd0);
    chk("R1 unknown opcode", {16'd0, status_word}, {16'd0, 3'd5, 13'd0});
    chk("R1 unknown opcode enables", {30'd0, rx_en, tx_en}, 32'd0);

    phase = "R3";
    step(1'b1, 5'd4, 11'd0, 8'd0);
    chk("R3 rx enable", {31'd0, rx_en}, 32'd1);
    step(1'b1, 5'd5, 11'd0, 8'd0);
    chk("R3 rx reset pulse", {30'd0, rx_rst, rx_en}, 32'd2);
    idle();
    chk("R3 rx reset one cycle", {31'd0, rx_rst}, 32'd0);
    step(1'b1, 5'd4, 11'd0, 8'd0);
    step(1'b1, 5'd3, 11'd0, 8'd0);
    chk("R3 rx disable", {31'd0, rx_en}, 32'd0);

    phase = "R4";
    step(1'b1, 5'd9, 11'd0, 8'd0);
    chk("R4 tx enable", {31'd0, tx_en}, 32'd1);
    step(1'b1, 5'd11, 11'd0, 8'd0);
    chk("R4 tx reset pulse", {30'd0, tx_rst, tx_en}, 32'd2);
    idle();
    chk("R4 tx reset one cycle", {31'd0, tx_rst}, 32'd0);
    step(1'b1, 5'd9, 11'd0, 8'd0);
    step(1'b1, 5'd10, 11'd0, 8'd0);
    chk("R4 tx disable", {31'd0, tx_en}, 32'd0);

    phase = "R5";
    step(1'b0, 5'd0, 11'd0, 8'hFF);
    chk("R5 events latched unmasked", {24'd0, status_word[7:0]}, 32'hBE);
    chk("R5 no irq with zero mask", {31'd0, irq}, 32'd0);

    phase = "R7";
    step(1'b1, 5'd13, 11'h00C, 8'd0);
    chk("R7 selective ack", {24'd0, status_word[7:0]}, 32'hB2);

    phase = "R8";
    step(1'b1, 5'd14, 11'h010, 8'd0);
    chk("R8 mask raises irq", {31'd0, irq}, 32'd1);
    chk("R8 latch bit", {31'd0, status_word[0]}, 32'd1);
    step(1'b1, 5'd13, 11'h010, 8'd0);
    chk("R8 irq drops after ack", {31'd0, irq}, 32'd0);

    phase = "R6";
    step(1'b1, 5'd12, 11'h7FF, 8'd0);
    chk("R6 request sets bit6", {31'd0, status_word[6]}, 32'd1);
    step(1'b1, 5'd14, 11'h040, 8'd0);
    chk("R6 request irq when unmasked", {31'd0, irq}, 32'd1);

    phase = "R5";
    step(1'b1, 5'd13, 11'h0FF, 8'h10);
    chk("R5 set beats ack", {24'd0, status_word[7:0]}, 32'h10);

    phase = "R9";
    step(1'b1, 5'd16, 11'h7FA, 8'd0);
    chk("R9 filter load", {28'd0, rx_filter}, 32'hA);

    phase = "R10";
    step(1'b1, 5'd4, 11'd0, 8'h3E);
    step(1'b1, 5'd0, 11'h7FF, 8'd0);
    n = 0;
    while (status_word[12] && n < 100) begin
      n++;
      step(1'b1, 5'd1, 11'd3, 8'hFF);
    end
    chk("R10 busy length", n, RST_N_CYC);
    chk("R10 cleared status", {16'd0, status_word}, 32'd0);
    chk("R10 cleared filter/en", {26'd0, rx_filter, rx_en, tx_en}, 32'd0);
    step(1'b1, 5'd1, 11'd6, 8'd0);
    chk("R10 accepts after busy", {29'd0, status_word[15:13]}, 32'd6);

    phase = "R1 random";
    for (int i = 0; i < 1500; i++) begin
      logic [4:0] op;
      int pick;
      pick = $urandom_range(0, 99);
      if (pick < 2) op = 5'd0;
      else op = 5'($urandom_range(0, 31));
      step(($urandom_range(0, 3) != 0), op, 11'($urandom), 8'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule